// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the master side of a three-wire link to a 12-bit serial converter. It owns the serial clock, watches the converter's busy line and reads one sixteen-bit frame each time software asks for a result. A frame begins only after busy reports end of conversion. The block can either test the busy level or wait for a fresh high-to-low transition of busy. Once a frame is under way, a select level gates the raw clock. The controller then produces sixteen clock pulses and captures one serial bit on each falling edge, most significant bit first.

Each frame starts with leading zero positions and ends with the twelve-bit code. The block extracts the code, checks the zero positions, and presents the word with a one-cycle strobe. A tolerant option covers links where the first leading zero is lost to gating and access delays. The half-period of the serial clock comes from a parameter. The block raises that value when it would push the serial clock above the converter's 15 MHz ceiling.

Top module: `adc_serial_reader`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, sel_out, sclk_out, data_valid and lz_err are 0 and data_out is 0.
- R2: Every frame puts exactly 16 rising edges on sclk_out. sel_out stays high from before the first rising edge until after the last falling edge, and sclk_out is low whenever sel_out is low.
- R3: Every high phase of sclk_out lasts H system cycles, and so does every low phase between select rising and each rising edge. H is the larger of HALF_CYCLES and ceil(SYS_CLK_HZ / (2 * MAX_SCLK_HZ)). With SYS_CLK_HZ = 100 MHz, MAX_SCLK_HZ = 15 MHz and HALF_CYCLES = 1, H is 4.
- R4: sdata_in is sampled at each falling edge of sclk_out. The bits form a 16-bit word s, with the first sampled bit in s[15]. With tolerant = 0, data_out = s[11:0].
- R5: With tolerant = 1 (the first leading zero is treated as missed), data_out = s[12:1], s[0] is discarded and only s[15:13] are leading-zero positions.
- R6: lz_err is 1 when any leading-zero position holds a 1: s[15:12] with tolerant = 0, s[15:13] with tolerant = 1. data_out is still updated in that case.
- R7: data_valid is a single-cycle pulse in the system cycle after the 16th falling edge. data_out and lz_err change only with that pulse and hold until the next one.
- R8: sel_out is high in the cycle of data_valid and low in the cycle that follows.
- R9: With busy_mode = 0 (polled), a start_req with busy_in low starts a frame. A start_req with busy_in high is held pending and starts a frame once busy_in is seen low.
- R10: With busy_mode = 1 (edge), a frame starts only on a high-to-low transition of busy_in seen after start_req. A busy_in that is already low does not start one.
- R11: A start_req that arrives while a frame is running is ignored, so that frame produces no second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request one read, single-cycle pulse |
| busy_mode | input | 1 | 0 = poll busy level, 1 = wait for busy falling edge |
| tolerant | input | 1 | 1 = first leading zero may be missing |
| busy_in | input | 1 | Converter busy, high during conversion (asynchronous) |
| sdata_in | input | 1 | Serial data from converter |
| sclk_out | output | 1 | Gated serial clock to converter |
| sel_out | output | 1 | Active-high select / clock enable |
| data_out | output | 12 | Last conversion code |
| data_valid | output | 1 | One-cycle strobe for data_out |
| lz_err | output | 1 | Leading-zero position captured as 1 |

## Verification
Each frame is played from a 16-bit stream that the bench drives bit by bit on the rising edges of sclk_out. The streams mix clean codes at both extremes with streams that carry a 1 in one of the leading positions. That set tells an MSB-first capture from a reversed or shifted one, and it tells the tolerant extraction window from the normal one. Bit 12 of the stream is set in both modes: it marks an error in normal mode, and in tolerant mode it is a data bit. The busy line is driven high at the request, left low before it, and toggled after it, which separates polled start from edge start and pending requests from ignored ones.

// File: rtl/adc_rd_pkg.sv
// Package: shared constants, state encoding and helpers for the serial ADC reader.
package adc_rd_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;
    localparam int LZ_BITS    = FRAME_BITS - DATA_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_DONE
    } rd_state_t;

    // Integer division rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
// Module: adc_rd_sync
// Brings the asynchronous busy line into the clock domain and flags its
// high-to-low transitions. Assumes busy pulses are longer than STAGES+1
// cycles. The chain resets high (busy) so that no false edge appears after reset.
module adc_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_async,
    output logic busy_sync,
    output logic busy_fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchronizer stages, first stage samples the raw line.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= busy_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy used for the edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign busy_sync = chain[STAGES-1];
    assign busy_fall = prev & ~chain[STAGES-1];

endmodule

// File: rtl/adc_rd_seq.sv
// Module: adc_rd_seq
// Frame sequencer. Holds a request until busy allows it, raises select,
// then makes sixteen serial clock pulses of HALF cycles per phase. It marks
// each falling edge for the shifter and drops select one cycle after the
// final bit. Assumes busy_mode stays stable while a request is pending.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic busy_mode,
    input  logic busy_sync,
    input  logic busy_fall,
    output logic sclk_raw,
    output logic sel,
    output logic fall_evt,
    output logic last_evt
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0]    CNT_END = CW'(HALF - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_BITS - 1);

    rd_state_t        state;
    logic [CW-1:0]    cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             phase_end;
    logic             go;

    // Phase boundary and start condition.
    always_comb begin
        phase_end = (cnt == CNT_END);
        go        = busy_mode ? busy_fall : ~busy_sync;
    end

    assign fall_evt = (state == ST_HIGH) && phase_end;
    assign last_evt = fall_evt && (bit_idx == IDX_END);

    // Main state machine with the phase counter, bit index, clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            sclk_raw <= 1'b0;
            sel      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) state <= ST_PEND;
                end
                ST_PEND: begin
                    if (go) begin
                        state   <= ST_LEAD;
                        sel     <= 1'b1;
                        cnt     <= '0;
                        bit_idx <= '0;
                    end
                end
                ST_LEAD: begin
                    if (phase_end) begin
                        state    <= ST_HIGH;
                        sclk_raw <= 1'b1;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        sclk_raw <= 1'b0;
                        cnt      <= '0;
                        bit_idx  <= bit_idx + 1'b1;
                        state    <= (bit_idx == IDX_END) ? ST_DONE : ST_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        state    <= ST_HIGH;
                        sclk_raw <= 1'b1;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    state   <= ST_IDLE;
                    sel     <= 1'b0;
                    bit_idx <= '0;
                end
                default: begin
                    state    <= ST_IDLE;
                    sel      <= 1'b0;
                    sclk_raw <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_rd_shift.sv
// Module: adc_rd_shift
// Captures serial bits on the marked falling edges, MSB first. After the
// last bit it extracts the code, checks the leading-zero positions and
// strobes the result. Assumes tolerant is stable during the final bit.
module adc_rd_shift
    import adc_rd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall_evt,
    input  logic                 last_evt,
    input  logic                 sdata,
    input  logic                 tolerant,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 lz_err
);

    logic [FRAME_BITS-2:0]  shreg;
    logic [FRAME_BITS-1:0]  frame;
    logic [DATA_BITS-1:0]   code;
    logic                   bad_lead;

    // Whole frame as seen on the final falling edge, including the current bit.
    always_comb begin
        frame = {shreg, sdata};
        if (tolerant) begin
            code     = frame[DATA_BITS:1];
            bad_lead = |frame[FRAME_BITS-1:DATA_BITS+1];
        end else begin
            code     = frame[DATA_BITS-1:0];
            bad_lead = |frame[FRAME_BITS-1:DATA_BITS];
        end
    end

    // Shift register fed on every falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (fall_evt) shreg <= {shreg[FRAME_BITS-3:0], sdata};
    end

    // Result register and strobe, updated once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data   <= '0;
            lz_err <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= last_evt;
            if (last_evt) begin
                data   <= code;
                lz_err <= bad_lead;
            end
        end
    end

endmodule

// File: rtl/adc_serial_reader.sv
// Module: adc_serial_reader (top)
// Serial ADC read controller: busy synchronizer, frame sequencer and
// capture shifter. The serial clock reaching the converter is the raw
// clock ANDed with select. The half period is clamped so that the serial
// clock never exceeds MAX_SCLK_HZ at SYS_CLK_HZ.
module adc_serial_reader
    import adc_rd_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 100_000_000,
    parameter int MAX_SCLK_HZ = 15_000_000,
    parameter int HALF_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_req,
    input  logic                 busy_mode,
    input  logic                 tolerant,
    input  logic                 busy_in,
    input  logic                 sdata_in,
    output logic                 sclk_out,
    output logic                 sel_out,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 data_valid,
    output logic                 lz_err
);

    localparam int MIN_HALF = ceil_div(SYS_CLK_HZ, 2 * MAX_SCLK_HZ);
    localparam int H_EFF    = (HALF_CYCLES > MIN_HALF) ? HALF_CYCLES : MIN_HALF;

    logic busy_sync;
    logic busy_fall;
    logic sclk_raw;
    logic sel;
    logic fall_evt;
    logic last_evt;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_async (busy_in),
        .busy_sync  (busy_sync),
        .busy_fall  (busy_fall)
    );

    adc_rd_seq #(.HALF(H_EFF)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .busy_mode (busy_mode),
        .busy_sync (busy_sync),
        .busy_fall (busy_fall),
        .sclk_raw  (sclk_raw),
        .sel       (sel),
        .fall_evt  (fall_evt),
        .last_evt  (last_evt)
    );

    adc_rd_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_evt (fall_evt),
        .last_evt (last_evt),
        .sdata    (sdata_in),
        .tolerant (tolerant),
        .data     (data_out),
        .valid    (data_valid),
        .lz_err   (lz_err)
    );

    // Clock gating by select, as seen at the converter pin.
    assign sclk_out = sclk_raw & sel;
    assign sel_out  = sel;

endmodule

// File: rtl/adc_rd_checker.sv
// Module: adc_rd_checker
// Protocol checks on the reader's ports, attached by bind. Counts serial
// clock rising edges inside each select window.
module adc_rd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk_out,
    input logic        sel_out,
    input logic        data_valid,
    input logic [11:0] data_out,
    input logic        lz_err
);

    logic [4:0] rises;
    logic       sclk_q;

    // Rising edge count within the current select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rises  <= '0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_out;
            if (!sel_out)               rises <= '0;
            else if (sclk_out && !sclk_q) rises <= rises + 1'b1;
        end
    end

    // R2
    pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (rises == 5'd16));

    // R2
    sel_open_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_out) |-> !sclk_out);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> ($stable(data_out) && $stable(lz_err)));

    // R8
    sel_at_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> sel_out);

    // R8
    sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !sel_out);

endmodule

bind adc_serial_reader adc_rd_checker i_adc_rd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_out   (sclk_out),
    .sel_out    (sel_out),
    .data_valid (data_valid),
    .data_out   (data_out),
    .lz_err     (lz_err)
);

// File: tb/test_adc_serial_reader.sv
// Bench for adc_serial_reader: table of frames walked by one loop, then
// directed tests for the busy start modes.
module test_adc_serial_reader;

    localparam int SYS  = 100_000_000;
    localparam int MAXF = 15_000_000;
    localparam int HALF = 1;
    localparam int H_EXP = (SYS + 2 * MAXF - 1) / (2 * MAXF); // 4, above HALF
    localparam int NV = 8;
    // {tolerant, busy_mode, stream[15:0]}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0ABC},
        {1'b0, 1'b1, 16'h0FFF},
        {1'b0, 1'b0, 16'h8123},
        {1'b1, 1'b0, 16'h0B4B},
        {1'b1, 1'b1, 16'h2000},
        {1'b0, 1'b1, 16'h1800},
        {1'b0, 1'b0, 16'h0001},
        {1'b1, 1'b0, 16'h1000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        busy_mode = 1'b0;
    logic        tolerant = 1'b0;
    logic        busy_in = 1'b1;
    logic        sdata_in = 1'b0;
    logic        sclk_out;
    logic        sel_out;
    logic [11:0] data_out;
    logic        data_valid;
    logic        lz_err;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    logic [15:0] stream = 16'h0;
    int          bit_pos = 0;

    // monitor state
    int frames = 0, valids = 0, pulses = 0, pulses_at_valid = 0;
    int hi_run = 0, lo_run = 0, phase_bad = 0, gap_bad = 0;
    logic prev_sclk = 1'b0, prev_sel = 1'b0, prev_valid = 1'b0;
    logic sel_at_valid = 1'b0, sel_after_valid = 1'b1;
    logic [11:0] cap_data = '0;
    logic cap_err = 1'b0;

    adc_serial_reader #(
        .SYS_CLK_HZ(SYS), .MAX_SCLK_HZ(MAXF), .HALF_CYCLES(HALF), .SYNC_STAGES(2)
    ) i_adc_serial_reader (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .busy_mode(busy_mode),
        .tolerant(tolerant), .busy_in(busy_in), .sdata_in(sdata_in),
        .sclk_out(sclk_out), .sel_out(sel_out), .data_out(data_out),
        .data_valid(data_valid), .lz_err(lz_err)
    );

    always #5 clk = ~clk;

    // Converter model: next bit becomes valid shortly after each rising edge.
    always @(posedge sel_out) bit_pos = 0;
    always @(posedge sclk_out) begin
        #2;
        sdata_in = (bit_pos < 16) ? stream[15 - bit_pos] : 1'b0;
        bit_pos++;
    end

    // Port monitor sampled between clock edges.
    always @(negedge clk) begin
        if (prev_valid) sel_after_valid = sel_out;
        if (sel_out && !prev_sel) begin
            frames++; pulses = 0; lo_run = 0;
        end
        if (!sel_out && sclk_out) gap_bad++;
        if (sclk_out && !prev_sclk) begin
            pulses++;
            if (lo_run != H_EXP) phase_bad++;
            lo_run = 0;
        end
        if (sclk_out) hi_run++;
        else begin
            if (prev_sclk && hi_run != H_EXP) phase_bad++;
            hi_run = 0;
            if (sel_out) lo_run++;
        end
        if (data_valid) begin
            valids++; cap_data = data_out; cap_err = lz_err;
            pulses_at_valid = pulses; sel_at_valid = sel_out;
        end
        prev_valid = data_valid; prev_sclk = sclk_out; prev_sel = sel_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic logic [11:0] exp_data(input logic [15:0] s, input logic tol);
        return tol ? s[12:1] : s[11:0];
    endfunction

    function automatic logic exp_err(input logic [15:0] s, input logic tol);
        return tol ? |s[15:13] : |s[15:12];
    endfunction

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic wait_frame(input int f0, input string req);
        int n = 0;
        while (frames == f0 && n < 200) begin @(negedge clk); n++; end
        check(frames == f0 + 1, req, frames, f0 + 1);
    endtask

    task automatic wait_valid(input int v0, input string req);
        int n = 0;
        while (valids == v0 && n < 1000) begin @(negedge clk); n++; end
        @(negedge clk);
        check(valids == v0 + 1, req, valids, v0 + 1);
    endtask

    initial begin
        int f0, v0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({sel_out, sclk_out, data_valid, lz_err} == 4'b0, "R1 ctrl", {sel_out, sclk_out, data_valid, lz_err}, 0);
        check(data_out == 12'h0, "R1 data", data_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({sel_out, sclk_out, data_valid, lz_err} == 4'b0 && data_out == 0, "R1 after release",
              {sel_out, sclk_out, data_valid, lz_err}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] s;
            logic tol;
            s = VEC[i][15:0]; tol = VEC[i][17];
            @(negedge clk);
            tolerant = tol; busy_mode = VEC[i][16]; busy_in = 1'b1; stream = s;
            repeat (6) @(negedge clk);
            f0 = frames; v0 = valids;
            pulse_start();
            repeat (30) @(negedge clk);
            // R9 / R10: request held while busy high
            check(frames == f0, "R9 R10 pending while busy", frames, f0);
            busy_in = 1'b0;
            wait_frame(f0, "R9 R10 start after busy low");
            repeat (20) @(negedge clk);
            pulse_start(); // R11: mid-frame request
            wait_valid(v0, "R7 valid pulse");
            check(cap_data == exp_data(s, tol), tol ? "R5 data" : "R4 data", cap_data, exp_data(s, tol));
            check(cap_err == exp_err(s, tol), "R6 lz_err", cap_err, exp_err(s, tol));
            check(pulses_at_valid == 16, "R2 pulse count", pulses_at_valid, 16);
            check(sel_at_valid && !sel_after_valid, "R8 select drop", {sel_at_valid, sel_after_valid}, 2'b10);
            repeat (60) @(negedge clk);
            check(frames == f0 + 1 && valids == v0 + 1, "R11 mid-frame request ignored", frames, f0 + 1);
            check(data_out == exp_data(s, tol) && lz_err == exp_err(s, tol), "R7 hold",
                  data_out, exp_data(s, tol));
        end

        // R9: polled mode with busy already low starts at once
        @(negedge clk) busy_mode = 1'b0; tolerant = 1'b0; busy_in = 1'b0; stream = 16'h0555;
        repeat (5) @(negedge clk);
        f0 = frames; v0 = valids;
        pulse_start();
        repeat (3) @(negedge clk);
        check(frames == f0 + 1, "R9 immediate start", frames, f0 + 1);
        wait_valid(v0, "R9 frame completes");
        check(cap_data == 12'h555, "R4 data polled", cap_data, 12'h555);

        // R10: edge mode ignores a busy level that is already low
        @(negedge clk) busy_mode = 1'b1; stream = 16'h0AAA;
        f0 = frames; v0 = valids;
        pulse_start();
        repeat (50) @(negedge clk);
        check(frames == f0, "R10 low level ignored", frames, f0);
        busy_in = 1'b1;
        repeat (6) @(negedge clk);
        busy_in = 1'b0;
        wait_frame(f0, "R10 start on falling edge");
        wait_valid(v0, "R10 frame completes");
        check(cap_data == 12'hAAA && !cap_err, "R4 data edge", cap_data, 12'hAAA);

        // R3 and R2 across all frames
        check(phase_bad == 0, "R3 phase length", phase_bad, 0);
        check(gap_bad == 0, "R2 clock low while deselected", gap_bad, 0);
        finish_run();
    end

endmodule